// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block sits between the configuration registers of a programmable clock generator and its CPU clock synthesizer. It decides which multiplier/divider pair (an 8-bit N and a 7-bit M) and which 5-bit ratio/gear code the synthesizer uses. The candidate sources are the strap pins, captured once when reset is released, and a small register set written through a simple address/data write port. That register set holds a control byte, a select code and the programmed N and M values. A recovery controller can also force its own N, M and code while it holds its override input high.

Two control bits work independently. The programmable bit chooses where N and M come from: a parameterized default table indexed by the active code, or the programmed N/M registers. The override bit chooses where the code comes from: the captured straps or the programmed select code. In programmable mode, that code still sets the gear constant and the ratio to the other clock groups. The outputs are registered. Each time the active setting changes, the block gives a one-cycle load strobe so the synthesizer can reload. A write to N or M in programmable mode also gives a strobe, even when the written value equals the old one.

Top module: `clksel_top`

## Requirements
- R1: While reset is held, the programmable bit and the override bit are 0, `act_code` is 0, `act_n`/`act_m` equal the table entry for code 0, and `load_pulse` is 0.
- R2: `strap_code` is captured on the first rising clock edge after `rst_n` goes high. Later changes on `strap_code` have no effect on any output.
- R3: With the programmable bit (address 0, bit 0) at 0 and the override bit (address 0, bit 1) at 0, `act_code` is the captured strap value and `act_n`/`act_m` are the table entry for it.
- R4: With the programmable bit at 0 and the override bit at 1, `act_code` is the select code (address 1, bits 4:0) and `act_n`/`act_m` are the table entry for it.
- R5: With the programmable bit at 1, `act_n`/`act_m` are the programmed N (address 2, bits 7:0) and M (address 3, bits 6:0). `act_code` follows the straps or the select code according to the override bit.
- R6: The default table gives N = `TBL_N_BASE` + `TBL_N_STEP` × code (defaults 60 and 4) and M = `TBL_M` (default 12) for every code.
- R7: A register write accepted at clock edge k shows on the outputs after edge k+1. `load_pulse` is high for exactly the cycle in which the active N, M or code takes a new value.
- R8: In programmable mode, with no recovery override, a write to N or M raises `load_pulse` after edge k+1 even if the value is unchanged. In non-programmable mode, such a write changes no output and gives no pulse.
- R9: While `rcv_active` is high, the outputs follow `rcv_n`, `rcv_m` and `rcv_code`, one edge after they are sampled, and register writes do not affect the outputs. On release, the outputs return to the register-selected setting with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 5 | Strap pin code, captured after reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address (0 control, 1 select, 2 N, 3 M) |
| wr_data | input | 8 | Register write data |
| rcv_active | input | 1 | Recovery override active |
| rcv_n | input | 8 | Recovery N value |
| rcv_m | input | 7 | Recovery M value |
| rcv_code | input | 5 | Recovery ratio code |
| act_n | output | 8 | Active N to the synthesizer |
| act_m | output | 7 | Active M to the synthesizer |
| act_code | output | 5 | Active ratio/gear code |
| load_pulse | output | 1 | One-cycle reload strobe |

## Verification
The bench moves the straps after the capture edge. A design that kept sampling the straps would then change its code. It writes a select code while the override bit is clear, which must change nothing, and then sets that bit. A design that wired the bits to the wrong sources would pick the wrong code or the wrong N/M. It rewrites N with the same value in programmable mode, where a design that strobes only on a change of value would miss the reload, and writes N in non-programmable mode, where a stray strobe would show. It also writes N during a recovery override and checks that the outputs hold the recovery values until release, then jump to the new programmed N.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int CODE_W = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CODES  = 1 << CODE_W;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SEL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_N    = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_M    = 2'd3;

  localparam int CTRL_PROG_BIT = 0;
  localparam int CTRL_OVR_BIT  = 1;

  typedef struct packed {
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
    logic [CODE_W-1:0] code;
  } freq_t;

  // Default N for a select code: linear in the code.
  function automatic logic [N_W-1:0] tbl_n(input int base, input int step, input int code);
    return N_W'(base + step * code);
  endfunction

  function automatic logic [M_W-1:0] tbl_m(input int mval);
    return M_W'(mval);
  endfunction
endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_en,
  output logic              ovr_sel,
  output logic [CODE_W-1:0] sel_code,
  output logic [N_W-1:0]    prog_n,
  output logic [M_W-1:0]    prog_m,
  output logic [CODE_W-1:0] strap_lat,
  output logic              strap_armed,
  output logic              nm_touch
);
  logic wr_ctrl, wr_sel, wr_n, wr_m;

  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_sel  = wr_en && (wr_addr == ADR_SEL);
  assign wr_n    = wr_en && (wr_addr == ADR_N);
  assign wr_m    = wr_en && (wr_addr == ADR_M);

  // Strap capture: once, on the first edge after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_lat   <= '0;
      strap_armed <= 1'b0;
    end else if (!strap_armed) begin
      strap_lat   <= strap_code;
      strap_armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_en  <= 1'b0;
      ovr_sel  <= 1'b0;
      sel_code <= '0;
      prog_n   <= '0;
      prog_m   <= '0;
      nm_touch <= 1'b0;
    end else begin
      nm_touch <= wr_n || wr_m;
      if (wr_ctrl) begin
        prog_en <= wr_data[CTRL_PROG_BIT];
        ovr_sel <= wr_data[CTRL_OVR_BIT];
      end
      if (wr_sel) sel_code <= wr_data[CODE_W-1:0];
      if (wr_n)   prog_n   <= wr_data[N_W-1:0];
      if (wr_m)   prog_m   <= wr_data[M_W-1:0];
    end
  end
endmodule

// File: rtl/clksel_rom.sv
module clksel_rom
  import clksel_pkg::*;
#(
  parameter int N_BASE = 60,
  parameter int N_STEP = 4,
  parameter int M_DFLT = 12
) (
  input  logic [CODE_W-1:0] code,
  output logic [N_W-1:0]    n,
  output logic [M_W-1:0]    m
);
  logic [N_W-1:0] rom_n [CODES];
  logic [M_W-1:0] rom_m [CODES];

  for (genvar i = 0; i < CODES; i++) begin : g_entry
    assign rom_n[i] = tbl_n(N_BASE, N_STEP, i);
    assign rom_m[i] = tbl_m(M_DFLT);
  end

  assign n = rom_n[code];
  assign m = rom_m[code];
endmodule

// File: rtl/clksel_mux.sv
module clksel_mux
  import clksel_pkg::*;
#(
  parameter int N_BASE = 60,
  parameter int M_DFLT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              ovr_sel,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [CODE_W-1:0] strap_lat,
  input  logic [N_W-1:0]    prog_n,
  input  logic [M_W-1:0]    prog_m,
  input  logic              nm_touch,
  input  logic              rcv_active,
  input  logic [N_W-1:0]    rcv_n,
  input  logic [M_W-1:0]    rcv_m,
  input  logic [CODE_W-1:0] rcv_code,
  output logic [CODE_W-1:0] pick_code,
  input  logic [N_W-1:0]    rom_n,
  input  logic [M_W-1:0]    rom_m,
  output freq_t             act,
  output logic              load_pulse
);
  freq_t nxt;
  logic  changed, reload;

  assign pick_code = ovr_sel ? sel_code : strap_lat;

  always_comb begin
    if (rcv_active) begin
      nxt.n    = rcv_n;
      nxt.m    = rcv_m;
      nxt.code = rcv_code;
    end else begin
      nxt.code = pick_code;
      nxt.n    = prog_en ? prog_n : rom_n;
      nxt.m    = prog_en ? prog_m : rom_m;
    end
  end

  assign changed = (nxt != act);
  assign reload  = nm_touch && prog_en && !rcv_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act.n      <= tbl_n(N_BASE, 0, 0);
      act.m      <= tbl_m(M_DFLT);
      act.code   <= '0;
      load_pulse <= 1'b0;
    end else begin
      act        <= nxt;
      load_pulse <= changed || reload;
    end
  end
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int TBL_N_BASE = 60,
  parameter int TBL_N_STEP = 4,
  parameter int TBL_M      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rcv_active,
  input  logic [N_W-1:0]    rcv_n,
  input  logic [M_W-1:0]    rcv_m,
  input  logic [CODE_W-1:0] rcv_code,
  output logic [N_W-1:0]    act_n,
  output logic [M_W-1:0]    act_m,
  output logic [CODE_W-1:0] act_code,
  output logic              load_pulse
);
  logic              prog_en, ovr_sel, strap_armed, nm_touch;
  logic [CODE_W-1:0] sel_code, strap_lat, pick_code;
  logic [N_W-1:0]    prog_n, rom_n;
  logic [M_W-1:0]    prog_m, rom_m;
  freq_t             act;

  clksel_regs u_regs (
    .clk, .rst_n, .strap_code, .wr_en, .wr_addr, .wr_data,
    .prog_en, .ovr_sel, .sel_code, .prog_n, .prog_m,
    .strap_lat, .strap_armed, .nm_touch
  );

  clksel_rom #(.N_BASE(TBL_N_BASE), .N_STEP(TBL_N_STEP), .M_DFLT(TBL_M)) u_rom (
    .code(pick_code), .n(rom_n), .m(rom_m)
  );

  clksel_mux #(.N_BASE(TBL_N_BASE), .M_DFLT(TBL_M)) u_mux (
    .clk, .rst_n, .prog_en, .ovr_sel, .sel_code, .strap_lat,
    .prog_n, .prog_m, .nm_touch, .rcv_active, .rcv_n, .rcv_m, .rcv_code,
    .pick_code, .rom_n, .rom_m, .act, .load_pulse
  );

  assign act_n    = act.n;
  assign act_m    = act.m;
  assign act_code = act.code;
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
  import clksel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              prog_en,
  input logic              strap_armed,
  input logic [CODE_W-1:0] strap_lat,
  input logic              nm_touch,
  input logic [N_W-1:0]    prog_n,
  input logic              rcv_active,
  input logic [N_W-1:0]    rcv_n,
  input logic [M_W-1:0]    rcv_m,
  input logic [CODE_W-1:0] rcv_code,
  input logic [N_W-1:0]    act_n,
  input logic [M_W-1:0]    act_m,
  input logic [CODE_W-1:0] act_code,
  input logic              load_pulse
);
  // R2: captured straps never move once armed
  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_armed |=> $stable(strap_lat));

  // R7: any change of the active setting comes with the strobe
  a_r7_change_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    ({act_n, act_m, act_code} != $past({act_n, act_m, act_code})) |-> load_pulse);

  // R8: N/M write in programmable mode reloads
  a_r8_nm_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (nm_touch && prog_en && !rcv_active) |=> load_pulse);

  // R5: programmed N reaches the output
  a_r5_prog_n: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !rcv_active) |=> (act_n == $past(prog_n)));

  // R9: recovery values win
  a_r9_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_active |=> (act_n == $past(rcv_n) && act_m == $past(rcv_m)
                    && act_code == $past(rcv_code)));
endmodule

bind clksel_top clksel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .strap_armed(strap_armed),
  .strap_lat(strap_lat), .nm_touch(nm_touch), .prog_n(prog_n),
  .rcv_active(rcv_active), .rcv_n(rcv_n), .rcv_m(rcv_m), .rcv_code(rcv_code),
  .act_n(act_n), .act_m(act_m), .act_code(act_code), .load_pulse(load_pulse)
);

// File: tb/sim_clksel_top.sv
`timescale 1ns/1ps
module sim_clksel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap_code = 5'd9;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rcv_active = 1'b0;
  logic [7:0] rcv_n = 8'd0;
  logic [6:0] rcv_m = 7'd0;
  logic [4:0] rcv_code = 5'd0;
  logic [7:0] act_n;
  logic [6:0] act_m;
  logic [4:0] act_code;
  logic       load_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  clksel_top u0 (
    .clk, .rst_n, .strap_code, .wr_en, .wr_addr, .wr_data,
    .rcv_active, .rcv_n, .rcv_m, .rcv_code,
    .act_n, .act_m, .act_code, .load_pulse
  );

  function automatic int dflt_n(input int code);
    return code * 4 + 60;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic expect_out(input string req, input int n, input int m, input int code, input int pulse);
    chk(req, "act_n", int'(act_n), n);
    chk(req, "act_m", int'(act_m), m);
    chk(req, "act_code", int'(act_code), code);
    chk(req, "load_pulse", int'(load_pulse), pulse);
  endtask

  // Write accepted at the next edge; returns at the following falling edge.
  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_and_strap();
    repeat (3) @(negedge clk);
    expect_out("R1", dflt_n(0), 12, 0, 0);
    rst_n = 1'b1;
    settle();
    settle();
    expect_out("R3", dflt_n(9), 12, 9, 1);
    strap_code = 5'd3;
    settle();
    chk("R7", "pulse width", int'(load_pulse), 0);
    repeat (3) settle();
    expect_out("R2", dflt_n(9), 12, 9, 0);
  endtask

  task automatic t_override();
    reg_write(2'd1, 8'd20);
    settle();
    expect_out("R4", dflt_n(9), 12, 9, 0);
    reg_write(2'd0, 8'h02);
    chk("R7", "latency", int'(act_code), 9);
    settle();
    expect_out("R4", dflt_n(20), 12, 20, 1);
    chk("R6", "table top", dflt_n(31), 184);
    reg_write(2'd1, 8'd31);
    settle();
    expect_out("R6", dflt_n(31), 12, 31, 1);
    reg_write(2'd1, 8'd20);
    settle();
  endtask

  task automatic t_program();
    reg_write(2'd2, 8'd100);
    settle();
    expect_out("R8", dflt_n(20), 12, 20, 0);
    reg_write(2'd3, 8'd50);
    settle();
    expect_out("R8", dflt_n(20), 12, 20, 0);
    reg_write(2'd0, 8'h03);
    settle();
    expect_out("R5", 100, 50, 20, 1);
    settle();
    chk("R7", "pulse width", int'(load_pulse), 0);
    reg_write(2'd2, 8'd100);
    settle();
    expect_out("R8", 100, 50, 20, 1);
    reg_write(2'd0, 8'h01);
    settle();
    expect_out("R5", 100, 50, 9, 1);
  endtask

  task automatic t_recovery();
    @(negedge clk);
    rcv_n = 8'd77; rcv_m = 7'd33; rcv_code = 5'd4; rcv_active = 1'b1;
    settle();
    expect_out("R9", 77, 33, 4, 1);
    reg_write(2'd2, 8'd200);
    settle();
    expect_out("R9", 77, 33, 4, 0);
    rcv_active = 1'b0;
    settle();
    expect_out("R9", 200, 50, 9, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected at most 5000", cycles);
      finish_run();
    end
  end

  initial begin
    t_reset_and_strap();
    t_override();
    t_program();
    t_recovery();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule